// File: doc/BRIEF.md
# Frame Bank Streamer

This block takes frames of already-compressed hit words from an upstream encoder, parks each frame in one of four memory banks, and sends finished frames out as a bit stream on one or two serial lanes. The writer takes the banks in turn. A new frame may only begin on a bank that holds nothing. While it fills, earlier frames drain to the lanes. If the bank that is next in turn is still occupied when a frame begins, the whole frame is thrown away and a lost-frame counter steps up.

Two readout policies are set by configuration. In streaming mode every finished frame goes out. In trigger-select mode a trigger pulse tags the frame being written and the frame finished just before it. Only tagged frames are sent. An untagged finished frame is released without being sent once a newer frame has been finished. Every sent frame is wrapped as a header word (sync tag and frame number), its data words in arrival order, and a trailer word (end tag and data word count). Words leave most significant bit first, one bit per clock. With two lanes enabled, consecutive words of a frame are dealt out alternately between the lanes. A lane with nothing to send repeats an idle word.

Top module: `frame_bank_streamer`

## Requirements
- R1: After reset both lanes send the idle word 0xAAAA repeatedly and the lost-frame count is 0. Word boundaries fall every 16 clocks, counted from the first clock edge after reset is released.
- R2: Accepted frames take banks in turn and are numbered 0, 1, 2, … in order of acceptance (8-bit number). A frame is accepted only when the next bank in turn is free. At most one bank is written and at most one is read at a time.
- R3: A frame that begins while the next bank is not free is dropped entirely: its words are never sent, the lost-frame count rises by exactly 1, and it uses no frame number.
- R4: A sent frame is the header {0xB8, frame number}, then the data words in the order written, then the trailer {0xE7, data word count}. Each 16-bit word is sent MSB first.
- R5: A bank holds at most 8 data words. Further words of the same frame are ignored, and the trailer then reports 8.
- R6: In streaming mode (trigger-select input low) every accepted frame is sent, oldest first, and the trigger input has no effect.
- R7: In trigger-select mode a trigger pulse tags the frame being written and the most recently finished frame. Only tagged frames are sent.
- R8: In trigger-select mode an untagged finished frame is discarded once a newer frame finishes. Its bank is freed, so continuous traffic causes no lost frames.
- R9: With two lanes enabled, frame word 0, 2, 4, … go to lane 0 and word 1, 3, 5, … go to lane 1 in the same word slot. When a frame has an odd total word count, lane 1 carries the idle word in the frame's last slot.
- R10: With one lane enabled, lane 1 carries only the idle word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trig_mode | input | 1 | 0 = streaming, 1 = trigger-select |
| cfg_two_lanes | input | 1 | 0 = lane 0 only, 1 = lanes 0 and 1 |
| frm_start | input | 1 | Pulse: a new frame begins |
| wr_valid | input | 1 | A data word of the current frame is present |
| wr_data | input | 16 | Data word |
| frm_end | input | 1 | Pulse: the current frame is complete |
| trig_in | input | 1 | Trigger pulse (trigger-select mode only) |
| ser_out | output | 2 | Serial bits, bit 0 = lane 0, bit 1 = lane 1 |
| frame_lost_cnt | output | 8 | Count of dropped frames |

## Verification
A bank whose status is wrong shows up in one of two ways. It may never become free, so the lost-frame count starts rising within the next four frames. Or it may be read or released at the wrong moment, so a frame goes missing or appears that should not, and the next header on the lanes carries an unexpected frame number. A wrong word index or lane split corrupts the stream within one 16-clock word slot. The decoder on the bench therefore compares every header, data word and trailer against a model of accepted and tagged frames. It checks the lost-frame count after each scenario.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [1:0] {
        BK_FREE    = 2'd0,
        BK_WRITING = 2'd1,
        BK_FULL    = 2'd2,
        BK_READING = 2'd3
    } bank_st_e;
endpackage

// File: rtl/fbs_bank_store.sv
module fbs_bank_store #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 8,
    parameter int BANKS  = 4,
    parameter int ADDR_W = 3,
    parameter int BI_W   = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BI_W-1:0]   wbank,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BI_W-1:0]   rbank,
    input  logic [ADDR_W-1:0] raddr0,
    input  logic [ADDR_W-1:0] raddr1,
    output logic [WORD_W-1:0] rdata0,
    output logic [WORD_W-1:0] rdata1
);
    localparam int CELLS = BANKS * DEPTH;

    logic [WORD_W-1:0] mem [CELLS];

    always_ff @(posedge clk) begin
        if (we) mem[int'(wbank) * DEPTH + int'(waddr)] <= wdata;
    end

    always_comb begin
        rdata0 = '0;
        rdata1 = '0;
        if (int'(raddr0) < DEPTH) rdata0 = mem[int'(rbank) * DEPTH + int'(raddr0)];
        if (int'(raddr1) < DEPTH) rdata1 = mem[int'(rbank) * DEPTH + int'(raddr1)];
    end
endmodule

// File: rtl/fbs_lane_ser.sv
module fbs_lane_ser #(
    parameter int                WORD_W    = 16,
    parameter logic [WORD_W-1:0] IDLE_WORD = 16'hAAAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              bit_o
);
    logic [WORD_W-1:0] sh_d, sh_q;

    always_comb begin
        if (load) sh_d = word;
        else      sh_d = {sh_q[WORD_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= IDLE_WORD;
        else        sh_q <= sh_d;
    end

    assign bit_o = sh_q[WORD_W-1];
endmodule

// File: rtl/frame_bank_streamer.sv
module frame_bank_streamer #(
    parameter int                  WORD_W    = 16,
    parameter int                  DEPTH     = 8,
    parameter int                  BANKS     = 4,
    parameter int                  LOST_W    = 8,
    parameter logic [WORD_W/2-1:0] HDR_TAG   = 8'hB8,
    parameter logic [WORD_W/2-1:0] TRL_TAG   = 8'hE7,
    parameter logic [WORD_W-1:0]   IDLE_WORD = 16'hAAAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_trig_mode,
    input  logic              cfg_two_lanes,
    input  logic              frm_start,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              frm_end,
    input  logic              trig_in,
    output logic [1:0]        ser_out,
    output logic [LOST_W-1:0] frame_lost_cnt
);
    import fbs_pkg::*;

    localparam int HALF   = WORD_W / 2;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int BI_W   = $clog2(BANKS);
    localparam int IX_W   = $clog2(DEPTH + 4);
    localparam int BC_W   = $clog2(WORD_W);

    typedef struct packed {
        logic [BANKS-1:0][1:0]       st;
        logic [BANKS-1:0]            mark;
        logic [BANKS-1:0][CNT_W-1:0] cnt;
        logic [BANKS-1:0][HALF-1:0]  fnum;
        logic [BI_W-1:0]             wr_ptr;
        logic [BI_W-1:0]             rd_ptr;
        logic [BI_W-1:0]             last_done;
        logic                        last_vld;
        logic                        rd_act;
        logic [IX_W-1:0]             widx;
        logic [BC_W-1:0]             bitcnt;
        logic [HALF-1:0]             fnum_next;
        logic [LOST_W-1:0]           lost;
    } ctl_t;

    ctl_t q, n;

    logic                  mem_we;
    logic [ADDR_W-1:0]     rd_a0, rd_a1;
    logic [WORD_W-1:0]     rd_w0, rd_w1;
    logic                  slot_end;
    logic [1:0][WORD_W-1:0] lane_word;
    logic [BANKS-1:0]      free_mask, writing_mask, full_mask, reading_mask;
    int                    base;

    function automatic logic [WORD_W-1:0] pick_word(input int idx, input int cnt,
                                                    input logic [HALF-1:0] fn,
                                                    input logic [WORD_W-1:0] dat);
        if (idx == 0)            return {HDR_TAG, fn};
        else if (idx <= cnt)     return dat;
        else if (idx == cnt + 1) return {TRL_TAG, HALF'(cnt)};
        else                     return IDLE_WORD;
    endfunction

    assign base  = q.rd_act ? int'(q.widx) : 0;
    assign rd_a0 = ADDR_W'(base - 1);
    assign rd_a1 = ADDR_W'(base);

    fbs_bank_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .BANKS(BANKS),
                     .ADDR_W(ADDR_W), .BI_W(BI_W)) u_store (
        .clk    (clk),
        .we     (mem_we),
        .wbank  (q.wr_ptr),
        .waddr  (q.cnt[q.wr_ptr][ADDR_W-1:0]),
        .wdata  (wr_data),
        .rbank  (q.rd_ptr),
        .raddr0 (rd_a0),
        .raddr1 (rd_a1),
        .rdata0 (rd_w0),
        .rdata1 (rd_w1)
    );

    always_comb begin
        int step;
        int total;
        logic eligible;
        n         = q;
        mem_we    = 1'b0;
        lane_word = {IDLE_WORD, IDLE_WORD};
        slot_end  = (q.bitcnt == BC_W'(WORD_W - 1));
        n.bitcnt  = slot_end ? '0 : q.bitcnt + 1'b1;

        // writer side
        if (q.st[q.wr_ptr] == BK_WRITING) begin
            if (wr_valid && (q.cnt[q.wr_ptr] < CNT_W'(DEPTH))) begin
                mem_we             = 1'b1;
                n.cnt[q.wr_ptr]    = q.cnt[q.wr_ptr] + 1'b1;
            end
            if (frm_end) begin
                n.st[q.wr_ptr] = BK_FULL;
                n.last_done    = q.wr_ptr;
                n.last_vld     = 1'b1;
                n.wr_ptr       = q.wr_ptr + 1'b1;
            end
        end else if (frm_start) begin
            if (q.st[q.wr_ptr] == BK_FREE) begin
                n.st[q.wr_ptr]   = BK_WRITING;
                n.cnt[q.wr_ptr]  = '0;
                n.mark[q.wr_ptr] = 1'b0;
                n.fnum[q.wr_ptr] = q.fnum_next;
                n.fnum_next      = q.fnum_next + 1'b1;
            end else begin
                n.lost = q.lost + 1'b1;
            end
        end

        // trigger tagging
        if (cfg_trig_mode && trig_in) begin
            if (q.st[q.wr_ptr] == BK_WRITING) n.mark[q.wr_ptr] = 1'b1;
            if (q.last_vld && (q.st[q.last_done] == BK_FULL)) n.mark[q.last_done] = 1'b1;
        end

        // reader side
        eligible = (q.st[q.rd_ptr] == BK_FULL) && (!cfg_trig_mode || q.mark[q.rd_ptr]);
        step     = cfg_two_lanes ? 2 : 1;
        total    = int'(q.cnt[q.rd_ptr]) + 2;
        if (!q.rd_act && cfg_trig_mode && (q.st[q.rd_ptr] == BK_FULL) && !q.mark[q.rd_ptr]
            && q.last_vld && (q.last_done != q.rd_ptr)) begin
            n.st[q.rd_ptr] = BK_FREE;
            n.rd_ptr       = q.rd_ptr + 1'b1;
        end else if (slot_end && (q.rd_act || eligible)) begin
            lane_word[0] = pick_word(base, int'(q.cnt[q.rd_ptr]), q.fnum[q.rd_ptr], rd_w0);
            if (cfg_two_lanes)
                lane_word[1] = pick_word(base + 1, int'(q.cnt[q.rd_ptr]), q.fnum[q.rd_ptr], rd_w1);
            if (base + step >= total) begin
                n.st[q.rd_ptr] = BK_FREE;
                n.rd_ptr       = q.rd_ptr + 1'b1;
                n.rd_act       = 1'b0;
            end else begin
                n.st[q.rd_ptr] = BK_READING;
                n.rd_act       = 1'b1;
                n.widx         = IX_W'(base + step);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    generate
        for (genvar l = 0; l < 2; l++) begin : g_lane
            fbs_lane_ser #(.WORD_W(WORD_W), .IDLE_WORD(IDLE_WORD)) u_ser (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (slot_end),
                .word  (lane_word[l]),
                .bit_o (ser_out[l])
            );
        end
        for (genvar b = 0; b < BANKS; b++) begin : g_mask
            assign free_mask[b]    = (q.st[b] == BK_FREE);
            assign writing_mask[b] = (q.st[b] == BK_WRITING);
            assign full_mask[b]    = (q.st[b] == BK_FULL);
            assign reading_mask[b] = (q.st[b] == BK_READING);
        end
    endgenerate

    assign frame_lost_cnt = q.lost;
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
    parameter int BANKS  = 4,
    parameter int LOST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_start,
    input logic [LOST_W-1:0] lost,
    input logic [BANKS-1:0]  free_mask,
    input logic [BANKS-1:0]  writing_mask,
    input logic [BANKS-1:0]  full_mask,
    input logic [BANKS-1:0]  reading_mask
);
    AST_ONE_READER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reading_mask)); // R2
    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(writing_mask)); // R2
    AST_LOST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lost != $past(lost)) |-> ((lost == LOST_W'($past(lost) + 1'b1)) && $past(frm_start))); // R3

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            AST_WRITE_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(writing_mask[b]) |-> $past(free_mask[b])); // R2
            AST_READ_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(reading_mask[b]) |-> $past(full_mask[b])); // R6
        end
    endgenerate
endmodule

bind frame_bank_streamer fbs_checker #(.BANKS(BANKS), .LOST_W(LOST_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_start    (frm_start),
    .lost         (frame_lost_cnt),
    .free_mask    (free_mask),
    .writing_mask (writing_mask),
    .full_mask    (full_mask),
    .reading_mask (reading_mask)
);

// File: tb/sim_frame_bank_streamer.sv
`timescale 1ns/1ps
module sim_frame_bank_streamer;
    localparam logic [15:0] IDLE = 16'hAAAA;
    localparam int NT = 6;
    localparam int TBL_LEN [NT] = '{3, 0, 8, 1, 5, 10};
    localparam int TBL_TRG [NT] = '{0, 1, 0, 2, 0, 0};
    localparam int TBL_EXP [NT] = '{3, 0, 8, 1, 5, 8};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_trig_mode = 1'b0, cfg_two_lanes = 1'b0;
    logic frm_start = 1'b0, wr_valid = 1'b0, frm_end = 1'b0, trig_in = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0] ser_out;
    logic [7:0] frame_lost_cnt;

    always #2.5 clk = ~clk;

    frame_bank_streamer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_trig_mode(cfg_trig_mode), .cfg_two_lanes(cfg_two_lanes),
        .frm_start(frm_start), .wr_valid(wr_valid), .wr_data(wr_data), .frm_end(frm_end),
        .trig_in(trig_in), .ser_out(ser_out), .frame_lost_cnt(frame_lost_cnt)
    );

    int n_chk = 0, n_fail = 0;
    string cur_tag = "R1";
    int exp_fn [64], exp_n [64], exp_seq [64];
    int exp_wr = 0, exp_rd = 0;
    int fn_m = 0, seq_m = 0;
    int n_edges = 0, dst = 0, dj = 0, lane1_bad = 0;
    logic [15:0] sr0 = '0, sr1 = '0, last_w0 = '0, last_w1 = '0;
    logic done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] dword(input int seq, input int j);
        return 16'(32'h1000 + seq * 16 + j);
    endfunction

    task take(input logic [15:0] w);
        case (dst)
            0: if (w != IDLE) begin
                if (w[15:8] == 8'hB8 && exp_rd < exp_wr) begin
                    chk("R2", 32'(w[7:0]), 32'(exp_fn[exp_rd] % 256));
                    dj  = 0;
                    dst = (exp_n[exp_rd] == 0) ? 2 : 1;
                end else begin
                    chk(cur_tag, 32'(w), 32'(IDLE)); // unexpected word on the lanes
                end
            end
            1: begin
                chk("R4", 32'(w), 32'(dword(exp_seq[exp_rd], dj)));
                dj++;
                if (dj == exp_n[exp_rd]) dst = 2;
            end
            default: begin
                chk(cur_tag, 32'(w), 32'({8'hE7, 8'(exp_n[exp_rd])}));
                exp_rd++;
                dst = 0;
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) n_edges <= 0;
        else        n_edges <= n_edges + 1;
    end

    always @(negedge clk) begin
        if (rst_n && n_edges >= 16) begin
            sr0 = {sr0[14:0], ser_out[0]};
            sr1 = {sr1[14:0], ser_out[1]};
            if (n_edges % 16 == 15) begin
                last_w0 = sr0;
                last_w1 = sr1;
                take(sr0);
                if (cfg_two_lanes) take(sr1);
                else if (sr1 != IDLE) lane1_bad++;
            end
        end
    end

    task automatic push(input int fn, input int seq, input int nexp);
        exp_fn[exp_wr]  = fn;
        exp_seq[exp_wr] = seq;
        exp_n[exp_wr]   = nexp;
        exp_wr++;
    endtask

    // trig_kind: 0 none, 1 with frm_end, 2 a few cycles after completion
    task automatic send_frame(input int len, input int trig_kind, output int seq);
        seq = seq_m;
        seq_m++;
        @(negedge clk) frm_start = 1'b1;
        @(negedge clk) frm_start = 1'b0;
        for (int j = 0; j < len; j++) begin
            wr_valid = 1'b1;
            wr_data  = dword(seq, j);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        frm_end  = 1'b1;
        trig_in  = (trig_kind == 1);
        @(negedge clk) begin frm_end = 1'b0; trig_in = 1'b0; end
        if (trig_kind == 2) begin
            repeat (4) @(negedge clk);
            trig_in = 1'b1;
            @(negedge clk) trig_in = 1'b0;
        end
    endtask

    task automatic wait_cyc(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(64);
        // R1: idle words on both lanes, nothing lost
        chk("R1", 32'(last_w0), 32'(IDLE));
        chk("R1", 32'(last_w1), 32'(IDLE));
        chk("R1", 32'(frame_lost_cnt), 0);

        // streaming mode, one lane: table walk (R6, R5 for the long frame)
        for (int i = 0; i < NT; i++) begin
            cur_tag = (TBL_LEN[i] > 8) ? "R5" : "R6";
            send_frame(TBL_LEN[i], TBL_TRG[i], s);
            push(fn_m, s, TBL_EXP[i]);
            fn_m++;
            wait_cyc(250);
            chk(cur_tag, 32'(exp_rd), 32'(exp_wr));
        end

        // R3: five frames back to back, the fifth finds its bank busy
        cur_tag = "R3";
        for (int i = 0; i < 5; i++) begin
            send_frame(2, 0, s);
            if (i < 4) begin
                push(fn_m, s, 2);
                fn_m++;
            end
        end
        wait_cyc(400);
        chk("R3", 32'(frame_lost_cnt), 1);
        chk("R3", 32'(exp_rd), 32'(exp_wr));
        send_frame(1, 0, s);  // next accepted frame takes the next number
        push(fn_m, s, 1);
        fn_m++;
        wait_cyc(200);
        chk("R3", 32'(exp_rd), 32'(exp_wr));
        chk("R10", 32'(lane1_bad), 0);

        // trigger-select mode: a, b, c(trig) -> b, c sent; d, e, f(trig after) -> f sent
        cfg_trig_mode = 1'b1;
        cur_tag = "R7";
        for (int i = 0; i < 6; i++) begin
            int kind;
            kind = (i == 2) ? 1 : ((i == 5) ? 2 : 0);
            send_frame(2 + i, kind, s);
            if (i == 1 || i == 2 || i == 5) push(fn_m, s, 2 + i);
            fn_m++;
            wait_cyc(250);
        end
        chk("R7", 32'(exp_rd), 32'(exp_wr));
        chk("R8", 32'(frame_lost_cnt), 1);
        // R8: released banks are reusable; four untagged frames then one tagged
        for (int i = 0; i < 5; i++) begin
            send_frame(1, (i == 4) ? 1 : 0, s);
            if (i >= 3) push(fn_m, s, 1);
            fn_m++;
            wait_cyc(120);
        end
        wait_cyc(200);
        chk("R8", 32'(exp_rd), 32'(exp_wr));
        chk("R8", 32'(frame_lost_cnt), 1);
        chk("R10", 32'(lane1_bad), 0);

        // R9: two lanes, streaming mode; odd, even and empty frames
        cfg_trig_mode = 1'b0;
        wait_cyc(40);
        cfg_two_lanes = 1'b1;
        cur_tag = "R9";
        for (int i = 0; i < 3; i++) begin
            int len;
            len = (i == 0) ? 3 : ((i == 1) ? 4 : 0);
            send_frame(len, 0, s);
            push(fn_m, s, len);
            fn_m++;
            wait_cyc(150);
            chk("R9", 32'(exp_rd), 32'(exp_wr));
        end
        chk("R9", 32'(frame_lost_cnt), 1);
        finish_run();
    end
endmodule